// File: doc/BRIEF.md
# CAN Receive Double-Buffer Controller

This block is the message store on the receive side of a CAN controller. It holds two message slots of thirteen bytes each. Each slot holds the control bits, a standard or extended identifier and up to eight data bytes. The back slot belongs to the bus-side receive engine, which fills it byte by byte while a frame arrives. The front slot is the only one the host can see, and it sees it through one fixed byte-address window. When a frame finishes correctly and passes the identifier filter, the block copies the back slot into the front slot, provided the front slot is free. It then raises a full flag and, if unmasked, a receive interrupt.

The host reads the message through the window and writes a clear strobe to release the front slot. Suppose a second good frame completes while the front slot is still occupied. The back slot then holds that frame as pending, and the block promotes it as soon as the host releases the front slot. If a third frame starts while both slots are occupied, the block discards that frame and sets a sticky overrun flag. It stays ready for the frame boundary that follows. Frames the node sent itself are written into the back slot but are never promoted, unless loop-back is on.

Top module: `canRxStore`

## Requirements
- R1: After reset, rxFull, ovrFlag, rxIrq and ovrIrq are all 0.
- R2: When frameDone and idMatch are both high for a promotable frame and rxFull is 0, the front slot takes the thirteen back-slot bytes at that clock edge. rxFull reads 1 from the next cycle on. Byte i is then read at hostAddr = i.
- R3: rxIrq is high exactly when rxFull is 1 and rxIntEn is 1. rxFull stays readable whatever the value of rxIntEn.
- R4: A hostClrFull pulse clears rxFull on the next edge. If a pending message is held, it is copied on the following edge and rxFull is 1 again. With nothing held, rxFull stays 0.
- R5: When a promotable frame completes while rxFull is 1, the front slot contents do not change, and the frame is held in the back slot as pending.
- R6: A frameStart while a pending message is held sets ovrFlag. The new frame's byte writes and its frameDone are ignored, so the held message is the one promoted later.
- R7: ovrFlag stays set until a hostClrOvr pulse, independent of rxFull. ovrIrq is high exactly when ovrFlag is 1 and ovrIntEn is 1.
- R8: Byte writes into the back slot happen whatever idMatch is. A frame that completes with idMatch low is not promoted, yet its bytes stay in the back slot. They therefore show through in later frames that write fewer bytes.
- R9: With loopBack 0, a frame completing with ownFrame 1 sets neither rxFull nor rxIrq, and the front slot is left unchanged.
- R10: With loopBack 1, a frame completing with ownFrame 1 is promoted like any other frame.
- R11: A hostClrFull pulse on the same cycle as a promotion (a new frame or a pending one) leaves rxFull at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Receive engine writes one back-slot byte |
| wrIdx | input | 4 | Byte index of that write (0..12) |
| wrData | input | 8 | Byte value to write |
| frameStart | input | 1 | Strobe: a new frame begins on the bus |
| frameDone | input | 1 | Strobe: the current frame completed without error |
| idMatch | input | 1 | Identifier filter result, valid with frameDone |
| ownFrame | input | 1 | Completed frame was sent by this node, valid with frameDone |
| loopBack | input | 1 | Loop-back mode: own frames are treated as received |
| hostAddr | input | 4 | Host byte address into the front slot |
| hostRdata | output | 8 | Front-slot byte at hostAddr (combinational) |
| hostClrFull | input | 1 | Host write-one strobe releasing the front slot |
| hostClrOvr | input | 1 | Host write-one strobe clearing the overrun flag |
| rxIntEn | input | 1 | Receive interrupt enable |
| ovrIntEn | input | 1 | Overrun interrupt enable |
| rxFull | output | 1 | Front slot holds an unread message |
| ovrFlag | output | 1 | Sticky overrun status |
| rxIrq | output | 1 | Receive interrupt request |
| ovrIrq | output | 1 | Overrun interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the host's release of the front slot and a promotion into it, with two ways to provoke it. In one, the release strobe is held for a second cycle, into the cycle in which a held message is being promoted. In the other, the release strobe is driven together with frameDone while the front slot is already empty. Both are judged by rxFull reading 1 afterwards and by the scoreboard finding the promoted message in the window. The second pair is the start of a frame and an occupied back slot, which is provoked by sending a third frame. It is judged by ovrFlag rising, and by the message promoted later matching the held frame rather than the dropped one.

// File: rtl/canRxPkg.sv
package canRxPkg;
  // Strobes from control to the buffer datapath
  typedef struct packed {
    logic bgWrEn;  // accept the current receive-engine byte into the back slot
    logic copyEn;  // copy whole back slot into the front slot this edge
  } bufCtlT;
endpackage

// File: rtl/canRxBuf.sv
module canRxBuf
  import canRxPkg::*;
#(
  parameter int MSG_BYTES = 13,
  parameter int ADDR_W    = $clog2(MSG_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufCtlT            ctl,
  input  logic [ADDR_W-1:0] wrIdx,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic [7:0]        hostRdata
);
  logic [MSG_BYTES-1:0][7:0] bgMem;
  logic [MSG_BYTES-1:0][7:0] fgMem;

  for (genvar gi = 0; gi < MSG_BYTES; gi++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bgMem[gi] <= '0;
        fgMem[gi] <= '0;
      end else begin
        if (ctl.bgWrEn && wrIdx == ADDR_W'(gi)) bgMem[gi] <= wrData;
        if (ctl.copyEn) fgMem[gi] <= bgMem[gi];
      end
    end
  end

  always_comb begin
    hostRdata = '0;
    for (int i = 0; i < MSG_BYTES; i++)
      if (hostAddr == ADDR_W'(i)) hostRdata = fgMem[i];
  end

  // R5
  fg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.copyEn |=> $stable(fgMem));
endmodule

// File: rtl/canRxCtrl.sv
module canRxCtrl
  import canRxPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrValid,
  input  logic   frameStart,
  input  logic   frameDone,
  input  logic   idMatch,
  input  logic   ownFrame,
  input  logic   loopBack,
  input  logic   hostClrFull,
  input  logic   hostClrOvr,
  input  logic   rxIntEn,
  input  logic   ovrIntEn,
  output bufCtlT ctl,
  output logic   rxFull,
  output logic   ovrFlag,
  output logic   rxIrq,
  output logic   ovrIrq
);
  logic bgPending;
  logic dropFrame;
  logic eligible, promoteNew, holdNew, promotePend, overrunHit;

  always_comb begin
    eligible    = frameDone && !dropFrame && !bgPending && idMatch
                  && (!ownFrame || loopBack);
    promoteNew  = eligible && !rxFull;
    holdNew     = eligible && rxFull;
    promotePend = bgPending && !rxFull;
    overrunHit  = frameStart && bgPending;
    ctl.copyEn  = promoteNew || promotePend;
    ctl.bgWrEn  = wrValid && !bgPending && !dropFrame;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull    <= 1'b0;
      bgPending <= 1'b0;
      dropFrame <= 1'b0;
      ovrFlag   <= 1'b0;
    end else begin
      // promotion wins over a simultaneous host release
      if (ctl.copyEn)       rxFull <= 1'b1;
      else if (hostClrFull) rxFull <= 1'b0;

      if (holdNew)          bgPending <= 1'b1;
      else if (promotePend) bgPending <= 1'b0;

      if (overrunHit)       dropFrame <= 1'b1;
      else if (frameDone)   dropFrame <= 1'b0;

      if (overrunHit)       ovrFlag <= 1'b1;
      else if (hostClrOvr)  ovrFlag <= 1'b0;
    end
  end

  assign rxIrq  = rxFull && rxIntEn;
  assign ovrIrq = ovrFlag && ovrIntEn;

  // R11
  promote_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.copyEn |=> rxFull);
  // R4
  pend_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bgPending && !rxFull) |=> (rxFull && !bgPending));
  // R6
  ovr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> dropFrame);
  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !hostClrOvr) |=> ovrFlag);
  // R3
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> rxFull);
endmodule

// File: rtl/canRxStore.sv
module canRxStore
  import canRxPkg::*;
#(
  parameter int MSG_BYTES = 13,
  parameter int ADDR_W    = $clog2(MSG_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrIdx,
  input  logic [7:0]        wrData,
  input  logic              frameStart,
  input  logic              frameDone,
  input  logic              idMatch,
  input  logic              ownFrame,
  input  logic              loopBack,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic [7:0]        hostRdata,
  input  logic              hostClrFull,
  input  logic              hostClrOvr,
  input  logic              rxIntEn,
  input  logic              ovrIntEn,
  output logic              rxFull,
  output logic              ovrFlag,
  output logic              rxIrq,
  output logic              ovrIrq
);
  bufCtlT ctl;

  canRxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .frameStart(frameStart),
    .frameDone(frameDone), .idMatch(idMatch), .ownFrame(ownFrame),
    .loopBack(loopBack), .hostClrFull(hostClrFull), .hostClrOvr(hostClrOvr),
    .rxIntEn(rxIntEn), .ovrIntEn(ovrIntEn), .ctl(ctl), .rxFull(rxFull),
    .ovrFlag(ovrFlag), .rxIrq(rxIrq), .ovrIrq(ovrIrq)
  );

  canRxBuf #(.MSG_BYTES(MSG_BYTES), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(wrIdx), .wrData(wrData),
    .hostAddr(hostAddr), .hostRdata(hostRdata)
  );
endmodule

// File: tb/canRxStore_bench.sv
module canRxStore_bench;
  localparam int NB = 13;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 0, frameStart = 0, frameDone = 0, idMatch = 0, ownFrame = 0, loopBack = 0;
  logic hostClrFull = 0, hostClrOvr = 0, rxIntEn = 0, ovrIntEn = 0;
  logic [AW-1:0] wrIdx = '0, hostAddr = '0;
  logic [7:0] wrData = '0, hostRdata;
  logic rxFull, ovrFlag, rxIrq, ovrIrq;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] expQ[$];

  always #5 clk = ~clk;

  canRxStore u_canRxStore (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIdx(wrIdx), .wrData(wrData),
    .frameStart(frameStart), .frameDone(frameDone), .idMatch(idMatch),
    .ownFrame(ownFrame), .loopBack(loopBack), .hostAddr(hostAddr),
    .hostRdata(hostRdata), .hostClrFull(hostClrFull), .hostClrOvr(hostClrOvr),
    .rxIntEn(rxIntEn), .ovrIntEn(ovrIntEn), .rxFull(rxFull), .ovrFlag(ovrFlag),
    .rxIrq(rxIrq), .ovrIrq(ovrIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver side: push the message the front slot should show next
  task automatic expectMsg(input logic [7:0] base, input int n, input logic [7:0] oldBase);
    for (int i = 0; i < NB; i++)
      expQ.push_back(i < n ? base + 8'(i) : oldBase + 8'(i));
  endtask

  // monitor side: pop expected bytes and compare with the host window
  task automatic compareMsg(input string req);
    int bad = 0;
    logic [7:0] e, a, badE, badA;
    badE = 0; badA = 0;
    for (int i = 0; i < NB; i++) begin
      hostAddr = AW'(i);
      @(negedge clk);
      e = expQ.pop_front();
      a = hostRdata;
      if (a !== e && bad == 0) begin badE = e; badA = a; end
      if (a !== e) bad++;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: window byte actual %0h expected %0h", req, badA, badE);
    end
  endtask

  task automatic sendFrame(input logic [7:0] base, input int n, input bit own,
                           input bit match, input bit clrAtDone);
    @(negedge clk) frameStart = 1;
    @(negedge clk) frameStart = 0;
    for (int i = 0; i < n; i++) begin
      wrValid = 1; wrIdx = AW'(i); wrData = base + 8'(i);
      @(negedge clk);
    end
    wrValid = 0; frameDone = 1; idMatch = match; ownFrame = own; hostClrFull = clrAtDone;
    @(negedge clk);
    frameDone = 0; idMatch = 0; ownFrame = 0; hostClrFull = 0;
  endtask

  task automatic pulseClrFull();
    hostClrFull = 1;
    @(negedge clk) hostClrFull = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    check("R1 full", rxFull, 0);
    check("R1 ovr", ovrFlag, 0);
    check("R1 irqs", {rxIrq, ovrIrq}, 0);

    rxIntEn = 1; ovrIntEn = 1;
    sendFrame(8'h10, NB, 0, 1, 0);
    check("R2 full", rxFull, 1);
    check("R3 irq on", rxIrq, 1);
    expectMsg(8'h10, NB, 0);
    compareMsg("R2 window");

    rxIntEn = 0; #1;
    check("R3 masked irq", rxIrq, 0);
    check("R3 flag pollable", rxFull, 1);
    rxIntEn = 1;

    sendFrame(8'h30, NB, 0, 1, 0);       // held as pending
    check("R5 full stays", rxFull, 1);
    expectMsg(8'h10, NB, 0);
    compareMsg("R5 front unchanged");

    sendFrame(8'h50, NB, 0, 1, 0);       // dropped
    check("R6 overrun", ovrFlag, 1);
    check("R7 ovr irq", ovrIrq, 1);

    pulseClrFull();
    check("R4 cleared", rxFull, 0);
    @(negedge clk);
    check("R4 repromoted", rxFull, 1);
    expectMsg(8'h30, NB, 0);
    compareMsg("R6 held msg promoted");

    check("R7 ovr sticky", ovrFlag, 1);
    ovrIntEn = 0; #1;
    check("R7 ovr irq masked", ovrIrq, 0);
    hostClrOvr = 1; @(negedge clk) hostClrOvr = 0;
    check("R7 ovr cleared", ovrFlag, 0);
    check("R7 full untouched", rxFull, 1);

    pulseClrFull();
    @(negedge clk);
    check("R4 stays empty", rxFull, 0);

    sendFrame(8'h70, NB, 1, 1, 0);
    check("R9 own no full", rxFull, 0);
    check("R9 own no irq", rxIrq, 0);

    sendFrame(8'h90, NB, 0, 0, 0);
    check("R8 no match no full", rxFull, 0);
    sendFrame(8'hB0, 4, 0, 1, 0);
    check("R8 partial full", rxFull, 1);
    expectMsg(8'hB0, 4, 8'h90);
    compareMsg("R8 filter-free overwrite");

    pulseClrFull();
    loopBack = 1;
    sendFrame(8'hD0, NB, 1, 1, 0);
    check("R10 loopback full", rxFull, 1);
    expectMsg(8'hD0, NB, 0);
    compareMsg("R10 loopback window");
    loopBack = 0;

    sendFrame(8'h20, NB, 0, 1, 0);       // pending
    pulseClrFull();
    check("R4 clr before collide", rxFull, 0);
    pulseClrFull();                      // same cycle as pending promotion
    check("R11 pend promote wins", rxFull, 1);
    expectMsg(8'h20, NB, 0);
    compareMsg("R11 pending window");

    pulseClrFull();
    check("R11 empty before", rxFull, 0);
    sendFrame(8'h40, NB, 0, 1, 1);       // clear together with frameDone
    check("R11 new promote wins", rxFull, 1);
    expectMsg(8'h40, NB, 0);
    compareMsg("R11 new window");

    finish();
  end
endmodule